// File: doc/BRIEF.md
# Extended Address Window Mapper

This block widens a 16-bit processor address bus to a 24-bit physical address. It produces the eight extra address lines, bits 23 down to 16, from the current CPU address and two 8-bit registers that software loads through I/O writes.

The first register is the bounds register. It marks a window of the 64 KB logical space in 4 KB blocks. The window is inclusive and is selected by address bits 15..12. The second register is the page register. It holds two 4-bit page numbers: one for accesses that fall inside the window and one for all other accesses. Only the low four extended lines carry a page number. The top four are tied low, which gives sixteen 64 KB pages in all.

The mapping path is purely combinational, so the extended lines follow the CPU address in the same cycle. A register write takes effect at the next clock edge. Software can read either register back through the same port selection that it uses to write it.

Top module: `xam_mapper`

## Requirements
- R1: After reset, the bounds register and the page register both read as 00 hex, and the extended address is 0 for every CPU address.
- R2: A write with ioWrEn high and ioSel=0 loads ioWrData into the bounds register. With ioSel=1 the write loads the page register instead. The new value is visible on ioRdData (ioSel=0 selects bounds, 1 selects page) after that clock edge.
- R3: While ioWrEn is low, neither register changes, whatever ioSel and ioWrData do.
- R4: Bounds bits 7..4 are the start block and bits 3..0 are the inclusive end block. An access with start <= cpuAddr[15:12] <= end drives page register bits 7..4 onto extAddr[3:0].
- R5: An access outside the window drives page register bits 3..0 onto extAddr[3:0].
- R6: When the end block is below the start block, the window is empty and every access uses page register bits 3..0. For example, 10 hex gives an empty window, and 8D hex covers blocks 8 to D.
- R7: extAddr[7:4] is always 0.
- R8: extAddr follows a change of cpuAddr without waiting for a clock edge.
- R9: A write to one register leaves the other register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| ioWrEn | input | 1 | Register write strobe |
| ioSel | input | 1 | Register select: 0 selects bounds, 1 selects page |
| ioWrData | input | 8 | Write data |
| ioRdData | output | 8 | Readback of the selected register |
| cpuAddr | input | 16 | CPU logical address |
| extAddr | output | 8 | Extended address lines 23..16 |

## Verification
The bench builds the block with its default parameters: a 16-bit address, 4-bit blocks and pages, and an 8-bit extended output. With these values the bounds register has only 256 settings, so the bench sweeps every one of them. For each setting it tests all sixteen 4 KB blocks, using a page value whose two nibbles always differ. This covers every combination of window start and end, including the empty, single-block and full-space windows, and shows which page nibble was chosen for each block.

// File: rtl/xam_pkg.sv
package xam_pkg;
  typedef struct packed {
    logic wrBounds;
    logic wrPage;
    logic rdPage;
  } xamStrobeT;
endpackage

// File: rtl/xam_ctrl.sv
module xam_ctrl
  import xam_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      ioWrEn,
  input  logic      ioSel,
  output xamStrobeT strb
);
  always_comb begin
    strb.wrBounds = ioWrEn & ~ioSel;
    strb.wrPage   = ioWrEn & ioSel;
    strb.rdPage   = ioSel;
  end

  AST_ONE_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrBounds, strb.wrPage})); // R9
endmodule

// File: rtl/xam_datapath.sv
module xam_datapath
  import xam_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int NIB_W  = 4,
  parameter int EXT_W  = 8,
  localparam int DATA_W = 2 * NIB_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  xamStrobeT         strb,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic [NIB_W-1:0]  addrBlk,
  output logic [EXT_W-1:0]  extAddr
);
  logic [DATA_W-1:0] boundsReg;
  logic [DATA_W-1:0] pageReg;
  logic [NIB_W-1:0]  startBlk;
  logic [NIB_W-1:0]  endBlk;
  logic [NIB_W-1:0]  selPage;
  logic              geStart;
  logic              leEnd;
  logic              inWindow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      boundsReg <= '0;
      pageReg   <= '0;
    end else begin
      if (strb.wrBounds) boundsReg <= wrData;
      if (strb.wrPage)   pageReg   <= wrData;
    end
  end

  always_comb begin
    startBlk = boundsReg[DATA_W-1:NIB_W];
    endBlk   = boundsReg[NIB_W-1:0];
    geStart  = (addrBlk >= startBlk);
    leEnd    = (addrBlk <= endBlk);
    inWindow = geStart & leEnd;
    selPage  = inWindow ? pageReg[DATA_W-1:NIB_W] : pageReg[NIB_W-1:0];
    extAddr  = {{(EXT_W-NIB_W){1'b0}}, selPage};
    rdData   = strb.rdPage ? pageReg : boundsReg;
  end

  AST_BOUNDS_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrBounds |=> boundsReg == $past(wrData)); // R2
  AST_PAGE_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrPage |=> pageReg == $past(wrData)); // R2
  AST_BOUNDS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrBounds |=> $stable(boundsReg)); // R3
  AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrPage |=> $stable(pageReg)); // R3
  AST_EMPTY_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    (endBlk < startBlk) |-> extAddr[NIB_W-1:0] == pageReg[NIB_W-1:0]); // R6
  AST_PAGE_CHOICE: assert property (@(posedge clk) disable iff (!rstN)
    (extAddr[NIB_W-1:0] == pageReg[NIB_W-1:0]) ||
    (extAddr[NIB_W-1:0] == pageReg[DATA_W-1:NIB_W])); // R4
endmodule

// File: rtl/xam_mapper.sv
module xam_mapper
  import xam_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int NIB_W  = 4,
  parameter int EXT_W  = 8,
  localparam int DATA_W = 2 * NIB_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ioWrEn,
  input  logic              ioSel,
  input  logic [DATA_W-1:0] ioWrData,
  output logic [DATA_W-1:0] ioRdData,
  input  logic [ADDR_W-1:0] cpuAddr,
  output logic [EXT_W-1:0]  extAddr
);
  xamStrobeT        strb;
  logic [NIB_W-1:0] addrBlk;
  logic             unusedAddrBits;

  assign addrBlk        = cpuAddr[ADDR_W-1 -: NIB_W];
  assign unusedAddrBits = ^cpuAddr[ADDR_W-NIB_W-1:0];

  xam_ctrl ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .ioWrEn (ioWrEn),
    .ioSel  (ioSel),
    .strb   (strb)
  );

  xam_datapath #(
    .ADDR_W (ADDR_W),
    .NIB_W  (NIB_W),
    .EXT_W  (EXT_W)
  ) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .wrData  (ioWrData),
    .rdData  (ioRdData),
    .addrBlk (addrBlk),
    .extAddr (extAddr)
  );
endmodule

// File: tb/xam_mapper_tb.sv
`timescale 1ns/1ps
module xam_mapper_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ioWrEn = 1'b0;
  logic        ioSel = 1'b0;
  logic [7:0]  ioWrData = '0;
  logic [7:0]  ioRdData;
  logic [15:0] cpuAddr = '0;
  logic [7:0]  extAddr;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  xam_mapper dut_i (
    .clk(clk), .rstN(rstN), .ioWrEn(ioWrEn), .ioSel(ioSel),
    .ioWrData(ioWrData), .ioRdData(ioRdData),
    .cpuAddr(cpuAddr), .extAddr(extAddr)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic writeReg(input logic sel, input logic [7:0] data);
    @(negedge clk);
    ioWrEn = 1'b1; ioSel = sel; ioWrData = data;
    @(negedge clk);
    ioWrEn = 1'b0; ioWrData = ~data;
  endtask

  task automatic readReg(input logic sel, output logic [7:0] val);
    ioSel = sel;
    #1;
    val = ioRdData;
  endtask

  function automatic logic [7:0] expExt(input logic [7:0] bnd, input logic [7:0] pg,
                                        input logic [3:0] blk);
    int s, e, b;
    s = bnd[7:4]; e = bnd[3:0]; b = blk;
    if (s <= b && b <= e) return {4'h0, pg[7:4]};
    return {4'h0, pg[3:0]};
  endfunction

  initial begin
    logic [7:0] rv;
    logic [7:0] bnd;
    logic [7:0] pg;
    logic [3:0] p;
    // R1: reset state
    #3;
    for (int b = 0; b < 16; b++) begin
      cpuAddr = {b[3:0], 12'h5A5};
      #1 check("R1 ext in reset", extAddr, 8'h00);
    end
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    readReg(1'b0, rv); check("R1 bounds reset", rv, 8'h00);
    readReg(1'b1, rv); check("R1 page reset", rv, 8'h00);

    // R2 / R9: loads and independence
    writeReg(1'b0, 8'h8D);
    readReg(1'b0, rv); check("R2 bounds load", rv, 8'h8D);
    readReg(1'b1, rv); check("R9 page kept", rv, 8'h00);
    writeReg(1'b1, 8'h3C);
    readReg(1'b1, rv); check("R2 page load", rv, 8'h3C);
    readReg(1'b0, rv); check("R9 bounds kept", rv, 8'h8D);

    // R3: no write while ioWrEn low
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      ioSel = i[0]; ioWrData = 8'hE1 + 8'(i);
    end
    @(negedge clk);
    readReg(1'b0, rv); check("R3 bounds unchanged", rv, 8'h8D);
    readReg(1'b1, rv); check("R3 page unchanged", rv, 8'h3C);

    // R4 R5 R6 R7 R8: full bounds sweep, address changed between edges
    for (int v = 0; v < 256; v++) begin
      bnd = 8'(v);
      p = bnd[3:0] ^ bnd[7:4];
      pg = {p, ~p};
      writeReg(1'b0, bnd);
      writeReg(1'b1, pg);
      @(posedge clk);
      #2;
      for (int b = 0; b < 16; b++) begin
        cpuAddr = {b[3:0], 12'(v * 37 + b * 101)};
        #0.25;
        if (bnd[3:0] < bnd[7:4])
          check("R6 empty window", extAddr, {4'h0, pg[3:0]});
        else if (expExt(bnd, pg, b[3:0]) == {4'h0, pg[7:4]})
          check("R4 inside window", extAddr, expExt(bnd, pg, b[3:0]));
        else
          check("R5 outside window", extAddr, expExt(bnd, pg, b[3:0]));
        check("R7 upper lines low", {4'h0, extAddr[7:4]}, 8'h00);
        check("R8 combinational", extAddr, expExt(bnd, pg, b[3:0]));
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule